// File: doc/BRIEF.md
# Display Source Selector with Binary-to-Decimal Digit Converter

This block decides which of four values is shown on a decimal seven-segment readout, then turns that value into decimal digits. A two-bit selector picks the source: the first 4-bit operand, the second 4-bit operand, the 3-bit operation code, or the 8-bit arithmetic result. Any source narrower than the result width has zeros added on the left to reach 8 bits.

The 8-bit value passes through a combinational shift-and-add-3 network with one stage per input bit. It produces a ones digit, a tens digit and a hundreds digit. The hundreds digit carries only three bits, so the 11-bit output holds hundreds[2:0], then tens[3:0], then ones[3:0], from most significant to least significant. A bypass input skips the conversion and presents the selected value as plain binary in the low bits instead. The block contains no registers. Segment decoding and the time-multiplexing of display digits are handled outside it.

Top module: `disp_bcd_top`

## Requirements
- R1: When `sel` is 2'b00, the displayed source is `opa`, zero-extended to 8 bits.
- R2: When `sel` is 2'b01, the displayed source is `opb`, zero-extended to 8 bits.
- R3: When `sel` is 2'b10, the displayed source is `opcode`, zero-extended to 8 bits.
- R4: When `sel` is 2'b11, the displayed source is the 8-bit `result`.
- R5: With `bypass` = 0, `disp_out[3:0]` equals the selected value modulo 10.
- R6: With `bypass` = 0, `disp_out[7:4]` equals (selected value / 10) modulo 10.
- R7: With `bypass` = 0, `disp_out[10:8]` equals the selected value / 100. For any 8-bit input, bit 10 is always 0.
- R8: With `bypass` = 1, `disp_out` equals the selected value zero-extended to 11 bits, so `disp_out[10:8]` is 0.
- R9: With `bypass` = 0, the ones and tens digit fields never exceed 9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sel | input | 2 | Source choice: 00 first operand, 01 second operand, 10 opcode, 11 result |
| opa | input | 4 | First operand |
| opb | input | 4 | Second operand |
| opcode | input | 3 | Operation code |
| result | input | 8 | Arithmetic result |
| bypass | input | 1 | 1 = plain binary output, 0 = decimal digits |
| disp_out | output | 11 | {hundreds[2:0], tens[3:0], ones[3:0]}, or the binary value when bypassed |

## Verification
The bench builds the block with its default parameters: 4-bit operands, a 3-bit opcode, an 8-bit result and an 11-bit output. At these widths the 8-bit source space is small enough to sweep in full. The bench therefore drives all 256 result values through the converter and through the bypass path, and compares each output with digits computed by division and modulo. It also walks every operand and opcode value through its selector setting. This shows that the padding zeros do not corrupt the low digits, and that the selector never leaks another source into the output.

// File: rtl/disp_pkg.sv
package disp_pkg;
  typedef enum logic [1:0] {
    SRC_OPA    = 2'b00,
    SRC_OPB    = 2'b01,
    SRC_OPCODE = 2'b10,
    SRC_RESULT = 2'b11
  } disp_src_e;

  localparam int DIGIT_W = 4;
endpackage

// File: rtl/disp_src_mux.sv
module disp_src_mux #(
  parameter int OPW  = 4,
  parameter int OCW  = 3,
  parameter int RESW = 8
) (
  input  logic [1:0]      sel,
  input  logic [OPW-1:0]  opa,
  input  logic [OPW-1:0]  opb,
  input  logic [OCW-1:0]  opcode,
  input  logic [RESW-1:0] result,
  output logic [RESW-1:0] val
);
  import disp_pkg::*;

  localparam int PAD_OP = RESW - OPW;
  localparam int PAD_OC = RESW - OCW;

  logic [RESW-1:0] ext_a, ext_b, ext_oc;

  assign ext_a  = {{PAD_OP{1'b0}}, opa};
  assign ext_b  = {{PAD_OP{1'b0}}, opb};
  assign ext_oc = {{PAD_OC{1'b0}}, opcode};

  always_comb begin
    unique case (disp_src_e'(sel))
      SRC_OPA:    val = ext_a;
      SRC_OPB:    val = ext_b;
      SRC_OPCODE: val = ext_oc;
      default:    val = result;
    endcase
  end

  always_comb begin
    // R1
    operand_pad_chk: assert (sel[1] || (val >> OPW) == '0)
      else $error("operand source carries nonzero upper bits");
    // R3
    opcode_pad_chk: assert (sel != 2'b10 || (val >> OCW) == '0)
      else $error("opcode source carries nonzero upper bits");
  end
endmodule

// File: rtl/dd_stage.sv
module dd_stage #(
  parameter int DIGS = 3
) (
  input  logic [DIGS*disp_pkg::DIGIT_W-1:0] bcd_in,
  input  logic                              bit_in,
  output logic [DIGS*disp_pkg::DIGIT_W-1:0] bcd_out
);
  import disp_pkg::*;

  localparam int DW = DIGS * DIGIT_W;

  logic [DW-1:0] adj;

  for (genvar d = 0; d < DIGS; d++) begin : g_dig
    logic [DIGIT_W-1:0] dig;
    assign dig = bcd_in[d*DIGIT_W +: DIGIT_W];
    assign adj[d*DIGIT_W +: DIGIT_W] = (dig >= 4'd5) ? dig + 4'd3 : dig;

    always_comb begin
      // R9
      stage_digit_chk: assert (dig <= 4'd9)
        else $error("intermediate digit above nine");
    end
  end

  assign bcd_out = {adj[DW-2:0], bit_in};
endmodule

// File: rtl/bcd_dd_conv.sv
module bcd_dd_conv #(
  parameter int BINW  = 8,
  parameter int DIGS  = 3,
  parameter int HUNDW = 3
) (
  input  logic [BINW-1:0]               bin,
  output logic [disp_pkg::DIGIT_W-1:0]  ones,
  output logic [disp_pkg::DIGIT_W-1:0]  tens,
  output logic [HUNDW-1:0]              hund
);
  import disp_pkg::*;

  localparam int DW = DIGS * DIGIT_W;

  logic [DW-1:0] chain [0:BINW];
  logic [DIGIT_W-1:0] hund_full;

  assign chain[0] = '0;

  for (genvar s = 0; s < BINW; s++) begin : g_stage
    dd_stage #(.DIGS(DIGS)) u_stage (
      .bcd_in (chain[s]),
      .bit_in (bin[BINW-1-s]),
      .bcd_out(chain[s+1])
    );
  end

  assign ones      = chain[BINW][0 +: DIGIT_W];
  assign tens      = chain[BINW][DIGIT_W +: DIGIT_W];
  assign hund_full = chain[BINW][2*DIGIT_W +: DIGIT_W];
  assign hund      = hund_full[HUNDW-1:0];

  always_comb begin
    // R7
    hund_cap_chk: assert (hund_full[DIGIT_W-1:HUNDW-1] == '0)
      else $error("hundreds digit wider than supported");
    // R5
    bcd_value_chk: assert (int'(hund_full) * 100 + int'(tens) * 10 + int'(ones) == int'(bin))
      else $error("digits do not recompose to input");
    // R9
    out_digit_chk: assert (ones <= 4'd9 && tens <= 4'd9)
      else $error("output digit above nine");
  end
endmodule

// File: rtl/disp_bcd_top.sv
module disp_bcd_top #(
  parameter int OPW  = 4,
  parameter int OCW  = 3,
  parameter int RESW = 8,
  parameter int OUTW = 11
) (
  input  logic [1:0]      sel,
  input  logic [OPW-1:0]  opa,
  input  logic [OPW-1:0]  opb,
  input  logic [OCW-1:0]  opcode,
  input  logic [RESW-1:0] result,
  input  logic            bypass,
  output logic [OUTW-1:0] disp_out
);
  import disp_pkg::*;

  localparam int HUNDW = OUTW - 2 * DIGIT_W;
  localparam int DIGS  = 3;

  logic [RESW-1:0]    val;
  logic [DIGIT_W-1:0] ones, tens;
  logic [HUNDW-1:0]   hund;

  disp_src_mux #(.OPW(OPW), .OCW(OCW), .RESW(RESW)) u_mux (
    .sel   (sel),
    .opa   (opa),
    .opb   (opb),
    .opcode(opcode),
    .result(result),
    .val   (val)
  );

  bcd_dd_conv #(.BINW(RESW), .DIGS(DIGS), .HUNDW(HUNDW)) u_conv (
    .bin (val),
    .ones(ones),
    .tens(tens),
    .hund(hund)
  );

  assign disp_out = bypass ? {{(OUTW-RESW){1'b0}}, val} : {hund, tens, ones};

  always_comb begin
    // R8
    bypass_hi_chk: assert (!bypass || disp_out[OUTW-1:RESW] == '0)
      else $error("bypass output has nonzero upper bits");
    // R7
    hund_top_chk: assert (bypass || !disp_out[OUTW-1])
      else $error("hundreds top bit set");
  end
endmodule

// File: tb/sim_disp_bcd_top.sv
module sim_disp_bcd_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [1:0]  sel;
  logic [3:0]  opa, opb;
  logic [2:0]  opcode;
  logic [7:0]  result;
  logic        bypass;
  logic [10:0] disp_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  disp_bcd_top u0 (
    .sel(sel), .opa(opa), .opb(opb), .opcode(opcode),
    .result(result), .bypass(bypass), .disp_out(disp_out)
  );

  function automatic logic [10:0] exp_dec(int v);
    logic [2:0] h;
    logic [3:0] t, o;
    h = 3'(v / 100);
    t = 4'((v / 10) % 10);
    o = 4'(v % 10);
    return {h, t, o};
  endfunction

  task automatic check(string req, logic [10:0] expv);
    checks++;
    if (disp_out !== expv) begin
      errors++;
      $display("FAIL %s sel=%0d bypass=%0d actual=%h expected=%h",
               req, sel, bypass, disp_out, expv);
    end
  endtask

  task automatic apply(logic [1:0] s, logic [3:0] a, logic [3:0] b,
                       logic [2:0] oc, logic [7:0] r, logic bp);
    @(posedge clk);
    sel = s; opa = a; opb = b; opcode = oc; result = r; bypass = bp;
    @(negedge clk);
  endtask

  task automatic t_reset_state();
    apply(2'b00, 4'd0, 4'd0, 3'd0, 8'd0, 1'b0);
    check("R1 zero", 11'd0);
  endtask

  task automatic t_operand_a();
    for (int i = 0; i < 16; i++) begin
      apply(2'b00, 4'(i), 4'(15 - i), 3'd7, 8'hFF, 1'b0);
      check("R1 R5 R6", exp_dec(i));
      apply(2'b00, 4'(i), 4'(15 - i), 3'd7, 8'hFF, 1'b1);
      check("R1 R8", 11'(i));
    end
  endtask

  task automatic t_operand_b();
    for (int i = 0; i < 16; i++) begin
      apply(2'b01, 4'(15 - i), 4'(i), 3'd5, 8'hC8, 1'b0);
      check("R2 R5 R6", exp_dec(i));
      apply(2'b01, 4'(15 - i), 4'(i), 3'd5, 8'hC8, 1'b1);
      check("R2 R8", 11'(i));
    end
  endtask

  task automatic t_opcode();
    for (int i = 0; i < 8; i++) begin
      apply(2'b10, 4'hF, 4'hA, 3'(i), 8'd255, 1'b0);
      check("R3", exp_dec(i));
      apply(2'b10, 4'hF, 4'hA, 3'(i), 8'd255, 1'b1);
      check("R3 R8", 11'(i));
    end
  endtask

  task automatic t_result_sweep();
    for (int v = 0; v < 256; v++) begin
      apply(2'b11, 4'(v), 4'(v >> 4), 3'(v), 8'(v), 1'b0);
      check("R4 R5 R6 R7 R9", exp_dec(v));
      if (disp_out[3:0] > 4'd9 || disp_out[7:4] > 4'd9 || disp_out[10]) begin
        errors++;
        $display("FAIL R9 digit range actual=%h expected=digits<=9,top=0", disp_out);
      end
      checks++;
    end
  endtask

  task automatic t_bypass_sweep();
    for (int v = 0; v < 256; v++) begin
      apply(2'b11, 4'd9, 4'd3, 3'd2, 8'(v), 1'b1);
      check("R4 R8", 11'(v));
    end
  endtask

  task automatic t_corners();
    apply(2'b11, 4'd0, 4'd0, 3'd0, 8'd99, 1'b0);
    check("R6 99", 11'h099);
    apply(2'b11, 4'd0, 4'd0, 3'd0, 8'd100, 1'b0);
    check("R7 100", 11'h100);
    apply(2'b11, 4'd0, 4'd0, 3'd0, 8'd255, 1'b0);
    check("R7 255", 11'h255);
    apply(2'b11, 4'd0, 4'd0, 3'd0, 8'd200, 1'b0);
    check("R7 200", 11'h200);
  endtask

  initial begin
    sel = '0; opa = '0; opb = '0; opcode = '0; result = '0; bypass = 1'b0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    t_reset_state();
    t_operand_a();
    t_operand_b();
    t_opcode();
    t_result_sweep();
    t_bypass_sweep();
    t_corners();
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule